// File: doc/BRIEF.md
# UART Receive/Transmit Line Status Tracker

This block assembles the eight-bit line status word for one UART channel that runs with receive and transmit FIFOs. The receiver hands it each received character with three error tags: bad parity, missing stop bit, and break. A break is a line held low for at least a whole character frame. The block keeps every character in a 64-entry receive FIFO with its tags beside it. The host pops characters off the FIFO head and sees the head character's tags, a data-ready flag, an overrun flag and a sticky summary flag. The summary flag stays up while any stored character is tagged.

A running count of the tagged entries inside the FIFO drives the summary flag. The count goes up when a tagged entry is written and down when a tagged entry is popped, so the flag drops by itself when the last tagged entry leaves the FIFO. A break that lasts for several frames arrives as several break-tagged pushes in a row. Only the first of these is stored, as a zero byte. On the transmit side the block watches the transmit FIFO fill level and the shift-register busy signal and derives two flags: holding side empty, and transmitter fully idle. Baud timing, serialisation and interrupt logic sit outside this block.

Top module: `uart_lsr_track`

## Requirements
- R1: After reset, with the transmit level at 0 and the shift register not busy, `line_status` reads 8'h60.
- R2: Bit 0 of `line_status` is 1 exactly when the receive FIFO holds at least one entry. `rx_head_byte` gives the entries in push order, and a pushed byte is visible one cycle after its push edge.
- R3: Bits 2, 3 and 4 of `line_status` are the parity-error, framing-error and break tags of the entry at the FIFO head. They read 0 when the FIFO is empty.
- R4: An entry pushed with the break tag is stored with data 8'h00, whatever the value on `rx_byte`.
- R5: A break-tagged push that follows a break-tagged push is discarded. Any push without the break tag re-arms the break capture.
- R6: A push that is not discarded and arrives while the FIFO holds 64 entries, with no pop accepted in the same cycle, is dropped and sets bit 1. A `stat_rd` strobe clears bit 1 one cycle later. A new overrun in the same cycle takes priority over the clear.
- R7: A pop while the FIFO is empty is ignored. The FIFO stays empty, and the next pushed byte is the one that comes out at the head.
- R8: Bit 7 of `line_status` is 1 while any stored entry carries at least one tag, and it returns to 0 once the last tagged entry has been popped.
- R9: A push and a pop in the same cycle while the FIFO is full are both accepted, and bit 1 does not set.
- R10: Bit 5 of `line_status` is 1 exactly when `tx_level` is 0.
- R11: Bit 6 of `line_status` is 1 exactly when `tx_level` is 0 and `tx_shift_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_push | input | 1 | Receiver delivers one character this cycle |
| rx_byte | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error tag for this character |
| rx_frm_err | input | 1 | Missing stop bit tag for this character |
| rx_brk | input | 1 | Break tag for this frame |
| rx_pop | input | 1 | Host removes the head entry |
| stat_rd | input | 1 | Host reads the status word (clears overrun) |
| tx_level | input | 7 | Current transmit FIFO fill level |
| tx_shift_busy | input | 1 | Transmit shift register holds a character |
| rx_head_byte | output | 8 | Data of the receive FIFO head entry |
| line_status | output | 8 | Status word: {any_err, tx_idle, thr_empty, brk, ferr, perr, overrun, data_ready} |

## Verification
The receive-side results (data ready, head byte, head tags, overrun and the summary flag) come from registers. They change one clock after the edge that takes the push, pop or status read. The two transmit flags follow `tx_level` and `tx_shift_busy` within the same cycle. The bench drives every input on the falling edge and checks on the next falling edge, so the registered results have passed exactly one rising edge and the transmit flags see the inputs that are still applied. A bench queue model, updated once per driven cycle, gives the expected values.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_tag_t;

  typedef struct packed {
    rx_tag_t           tag;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  function automatic logic tag_any(input rx_tag_t t);
    return t.brk | t.ferr | t.perr;
  endfunction
endpackage

// File: rtl/lsr_rx_front.sv
module lsr_rx_front
  import lsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] data,
  input  rx_tag_t           tag,
  input  logic              full,
  input  logic              pop_ok,
  input  logic              stat_rd,
  output logic              wr_en,
  output rx_entry_t         wr_entry,
  output logic              overrun
);
  logic brk_act_q, brk_act_d;
  logic ovr_q, ovr_d;
  logic collapse, cand, ovr_set;

  always_comb begin
    collapse       = push & tag.brk & brk_act_q;
    cand           = push & ~collapse;
    wr_en          = cand & (~full | pop_ok);
    ovr_set        = cand & full & ~pop_ok;
    wr_entry.tag   = tag;
    wr_entry.data  = tag.brk ? '0 : data;
    brk_act_d      = push ? tag.brk : brk_act_q;
    if (ovr_set)      ovr_d = 1'b1;
    else if (stat_rd) ovr_d = 1'b0;
    else              ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_act_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      brk_act_q <= brk_act_d;
      ovr_q     <= ovr_d;
    end
  end

  assign overrun = ovr_q;

  a_r5_break_collapsed: assert property (@(posedge clk) disable iff (!rst_n)
    (push && tag.brk && brk_act_q) |-> !wr_en);
  a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !collapse && full && !pop_ok) |=> overrun);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(push && full && !pop_ok)) |=> !overrun);
endmodule

// File: rtl/lsr_rx_store.sv
module lsr_rx_store
  import lsr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  rx_entry_t        wr_entry,
  input  logic             rd_req,
  output logic             rd_ok,
  output rx_entry_t        head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] level
);
  rx_entry_t        mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] level_q, level_d;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty    = (level_q == '0);
    full     = (level_q == CNT_W'(DEPTH));
    rd_ok    = rd_req & ~empty;
    wr_ptr_d = wr_en ? ptr_next(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = rd_ok ? ptr_next(rd_ptr_q) : rd_ptr_q;
    level_d  = level_q;
    if (wr_en && !rd_ok)      level_d = level_q + 1'b1;
    else if (!wr_en && rd_ok) level_d = level_q - 1'b1;
    head     = empty ? '0 : mem[rd_ptr_q];
    level    = level_q;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  a_r7_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty && !wr_en) |=> ($stable(rd_ptr_q) && level_q == '0));
  a_r4_break_stored_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_entry.tag.brk && empty) |=> (head.data == '0 && head.tag.brk));
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/lsr_err_count.sv
module lsr_err_count
  import lsr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  rx_tag_t          wr_tag,
  input  logic             rd_ok,
  input  rx_tag_t          head_tag,
  output logic [CNT_W-1:0] err_cnt,
  output logic             any_err
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic inc, dec;

  always_comb begin
    inc   = wr_en & tag_any(wr_tag);
    dec   = rd_ok & tag_any(head_tag);
    cnt_d = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + 1'b1;
    else if (!inc && dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign err_cnt = cnt_q;
  assign any_err = (cnt_q != '0);

  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && tag_any(head_tag)) |-> (cnt_q != '0));
endmodule

// File: rtl/lsr_tx_flags.sv
module lsr_tx_flags #(
  parameter int LVL_W = 7
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_shift_busy,
  output logic             thr_empty,
  output logic             tx_idle
);
  always_comb begin
    thr_empty = (tx_level == '0);
    tx_idle   = thr_empty & ~tx_shift_busy;
  end
endmodule

// File: rtl/uart_lsr_track.sv
module uart_lsr_track
  import lsr_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int TX_LVL_W = $clog2(TX_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_push,
  input  logic [DATA_W-1:0]   rx_byte,
  input  logic                rx_par_err,
  input  logic                rx_frm_err,
  input  logic                rx_brk,
  input  logic                rx_pop,
  input  logic                stat_rd,
  input  logic [TX_LVL_W-1:0] tx_level,
  input  logic                tx_shift_busy,
  output logic [DATA_W-1:0]   rx_head_byte,
  output logic [7:0]          line_status
);
  localparam int CNT_W = $clog2(RX_DEPTH + 1);

  logic [1:0]       rst_pipe;
  logic             rst_n_int;
  rx_tag_t          in_tag;
  logic             wr_en, rd_ok, empty, full, overrun, any_err;
  logic             thr_empty, tx_idle;
  rx_entry_t        wr_entry, head;
  logic [CNT_W-1:0] level, err_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  always_comb begin
    in_tag.brk  = rx_brk;
    in_tag.ferr = rx_frm_err;
    in_tag.perr = rx_par_err;
  end

  lsr_rx_front u_front (
    .clk(clk), .rst_n(rst_n_int), .push(rx_push), .data(rx_byte), .tag(in_tag),
    .full(full), .pop_ok(rd_ok), .stat_rd(stat_rd),
    .wr_en(wr_en), .wr_entry(wr_entry), .overrun(overrun)
  );

  lsr_rx_store #(.DEPTH(RX_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .wr_entry(wr_entry),
    .rd_req(rx_pop), .rd_ok(rd_ok), .head(head), .empty(empty), .full(full),
    .level(level)
  );

  lsr_err_count #(.DEPTH(RX_DEPTH)) u_errs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .wr_tag(wr_entry.tag),
    .rd_ok(rd_ok), .head_tag(head.tag), .err_cnt(err_cnt), .any_err(any_err)
  );

  lsr_tx_flags #(.LVL_W(TX_LVL_W)) u_tx (
    .tx_level(tx_level), .tx_shift_busy(tx_shift_busy),
    .thr_empty(thr_empty), .tx_idle(tx_idle)
  );

  always_comb begin
    rx_head_byte = head.data;
    line_status  = {any_err, tx_idle, thr_empty, head.tag.brk, head.tag.ferr,
                    head.tag.perr, overrun, ~empty};
  end

  a_r8_count_within_level: assert property (@(posedge clk) disable iff (!rst_n_int)
    err_cnt <= level);
  a_r11_idle_needs_empty: assert property (@(posedge clk) disable iff (!rst_n_int)
    line_status[6] |-> line_status[5]);
  a_r3_empty_no_tags: assert property (@(posedge clk) disable iff (!rst_n_int)
    !line_status[0] |-> (line_status[4:2] == 3'b000 && !line_status[7]));
endmodule

// File: tb/uart_lsr_track_tb_top.sv
module uart_lsr_track_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;

  logic       clk, rst_n;
  logic       rx_push, rx_par_err, rx_frm_err, rx_brk, rx_pop, stat_rd, tx_shift_busy;
  logic [7:0] rx_byte, rx_head_byte, line_status;
  logic [6:0] tx_level;

  int checks = 0;
  int fails  = 0;

  logic [10:0] mq[$];
  bit          m_ovr, m_brk;

  uart_lsr_track dut_i (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
    .rx_pop(rx_pop), .stat_rd(stat_rd), .tx_level(tx_level),
    .tx_shift_busy(tx_shift_busy), .rx_head_byte(rx_head_byte),
    .line_status(line_status)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    logic [10:0] h;
    bit anyerr;
    h = (mq.size() > 0) ? mq[0] : 11'h0;
    anyerr = 0;
    foreach (mq[i]) if (mq[i][10:8] != 3'b000) anyerr = 1;
    return {anyerr, (tx_level == 0) && !tx_shift_busy, tx_level == 0,
            h[10], h[9], h[8], m_ovr, mq.size() > 0};
  endfunction

  task automatic check_model();
    logic [7:0] e;
    e = exp_status();
    chk({7'b0, line_status[0]}, {7'b0, e[0]}, "R2 data ready");
    chk({7'b0, line_status[1]}, {7'b0, e[1]}, "R6 overrun");
    chk({5'b0, line_status[4:2]}, {5'b0, e[4:2]}, "R3 head tags");
    chk({7'b0, line_status[5]}, {7'b0, e[5]}, "R10 holding empty");
    chk({7'b0, line_status[6]}, {7'b0, e[6]}, "R11 transmitter idle");
    chk({7'b0, line_status[7]}, {7'b0, e[7]}, "R8 any error");
    if (mq.size() > 0) chk(rx_head_byte, mq[0][7:0], "R2 head byte");
  endtask

  task automatic step(input bit p, input logic [7:0] d, input bit pe, input bit fe,
                      input bit br, input bit pp, input bit rd,
                      input logic [6:0] tl, input bit tb);
    bit cand, do_pop, full, ovr_set;
    rx_push = p; rx_byte = d; rx_par_err = pe; rx_frm_err = fe; rx_brk = br;
    rx_pop = pp; stat_rd = rd; tx_level = tl; tx_shift_busy = tb;
    cand    = p && !(br && m_brk);
    do_pop  = pp && (mq.size() > 0);
    full    = (mq.size() == DEPTH);
    ovr_set = cand && full && !do_pop;
    if (p) m_brk = br;
    if (do_pop) void'(mq.pop_front());
    if (cand && !ovr_set) mq.push_back({br, fe, pe, br ? 8'h00 : d});
    if (ovr_set) m_ovr = 1;
    else if (rd) m_ovr = 0;
    @(posedge clk);
    @(negedge clk);
    check_model();
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ovr = 0; m_brk = 0;
    rst_n = 1'b0;
    rx_push = 0; rx_byte = 0; rx_par_err = 0; rx_frm_err = 0; rx_brk = 0;
    rx_pop = 0; stat_rd = 0; tx_level = 0; tx_shift_busy = 0;
    repeat (3) @(negedge clk);
    chk(line_status, 8'h60, "R1 status during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(line_status, 8'h60, "R1 reset status");

    // R7: pop on empty does nothing
    step(0, 8'h00, 0, 0, 0, 1, 0, 0, 0);
    chk({7'b0, line_status[0]}, 8'h00, "R7 empty after pop");
    step(1, 8'hA5, 0, 0, 0, 0, 0, 0, 0);
    chk(rx_head_byte, 8'hA5, "R7 head after empty pop");

    // R4/R3: break stored as zero with tag
    step(1, 8'hFF, 0, 0, 1, 1, 0, 0, 0);
    chk(rx_head_byte, 8'h00, "R4 break data zero");
    chk({7'b0, line_status[4]}, 8'h01, "R3 break tag at head");
    chk({7'b0, line_status[7]}, 8'h01, "R8 break raises any-error");

    // R5: repeated break pushes collapse
    step(1, 8'h11, 0, 0, 1, 0, 0, 0, 0);
    step(1, 8'h22, 1, 1, 1, 0, 0, 0, 0);
    step(1, 8'h3C, 0, 0, 0, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 1, 0, 0, 0);
    chk(rx_head_byte, 8'h3C, "R5 collapsed breaks");
    chk({7'b0, line_status[7]}, 8'h00, "R8 clears after tagged pop");
    step(0, 8'h00, 0, 0, 0, 1, 0, 0, 0);
    chk({7'b0, line_status[0]}, 8'h00, "R5 single break stored");

    // R6/R9: fill, overflow, read clear, push+pop while full
    for (int i = 0; i < DEPTH; i++)
      step(1, 8'(i + 1), (i == 40), 0, 0, 0, 0, 7'd5, 1);
    step(1, 8'hEE, 0, 0, 0, 0, 0, 0, 1);
    chk({7'b0, line_status[1]}, 8'h01, "R6 overrun sets");
    step(1, 8'hEF, 0, 0, 0, 0, 1, 0, 1);
    chk({7'b0, line_status[1]}, 8'h01, "R6 set beats read clear");
    step(0, 8'h00, 0, 0, 0, 0, 1, 0, 0);
    chk({7'b0, line_status[1]}, 8'h00, "R6 cleared by read");
    step(1, 8'h77, 0, 0, 0, 1, 0, 0, 0);
    chk({7'b0, line_status[1]}, 8'h00, "R9 push+pop while full");
    chk(rx_head_byte, 8'h02, "R9 head advanced");
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 0, 0, 0, 1, 0, 0, 0);
    chk({7'b0, line_status[7]}, 8'h00, "R8 cleared when drained");

    // R10/R11 transmit combinations
    step(0, 8'h00, 0, 0, 0, 0, 0, 7'd3, 0);
    chk({6'b0, line_status[6:5]}, 8'h00, "R10 level nonzero");
    step(0, 8'h00, 0, 0, 0, 0, 0, 7'd0, 1);
    chk({6'b0, line_status[6:5]}, 8'h01, "R11 busy shift register");
    step(0, 8'h00, 0, 0, 0, 0, 0, 7'd64, 1);
    chk({6'b0, line_status[6:5]}, 8'h00, "R10 full transmit level");

    // random mix, phases bias fill vs drain
    for (int n = 0; n < 4000; n++) begin
      int ph;
      bit p, pp;
      ph = (n / 500) % 2;
      p  = ($urandom_range(0, 9) < (ph ? 8 : 4));
      pp = ($urandom_range(0, 9) < (ph ? 2 : 6));
      step(p, 8'($urandom()), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 9) == 0), pp,
           ($urandom_range(0, 5) == 0), 7'($urandom_range(0, 3) == 0 ? 0 : $urandom_range(1, 64)),
           ($urandom_range(0, 1) == 1));
    end
    finish_run();
  end
endmodule